// File: doc/BRIEF.md
# Tiled View Address Generator

This block turns a pixel coordinate inside a two-dimensional tiled container into a 32-bit bus address for a particular view of that container. A view is one of eight rotations or mirrorings. The caller gives a pixel format, a 3-bit view code and the X and Y pixel coordinates. The block returns three things: the address, a flag that says whether the coordinate lay inside the container, and the line stride to use when walking the buffer in that view.

The top address bits carry the view code and the format code, so the memory side can decode how the access should be remapped. The lower bits carry the pixel offset. The width of each coordinate field depends on the format:

- Wider pixels leave fewer usable coordinate bits.
- Mirroring inverts the bits of a coordinate inside its field.
- A transposed view swaps which coordinate forms the upper part of the offset.

By default the result is registered, so it appears one cycle after the request, with a matching valid strobe.

Top module: `tiled_view_addr`

## Requirements
- R1: Address bits [28:27] carry the format code taken from `fmt`: 0 selects 8-bit tiles, 1 selects 16-bit tiles, 2 selects 32-bit tiles and 3 selects page mode.
- R2: Address bits [31:29] carry the view code exactly as given on `orient`. In that code, bit 0 inverts X, bit 1 inverts Y and bit 2 transposes the axes.
- R3: Each format drops a number of X bits and Y bits, written here as (X, Y). The drops are (0,0) for 8-bit, (0,1) for 16-bit and (1,1) for 32-bit. The X field is then 14 minus its drop wide and the Y field is 13 minus its drop wide. In page mode both fields are zero bits wide.
- R4: When the X-invert bit is set, X is replaced by X XOR the all-ones mask of the X field width. When the Y-invert bit is set, Y is treated the same way with the Y mask.
- R5: Without transposition the offset is (Y shifted left by the X field width) plus X. With transposition it is (X shifted left by the Y field width) plus Y. The offset is then shifted left by the sum of the two drops and placed in bits [26:0].
- R6: If X exceeds its mask or Y exceeds its mask, `addr` is 0 and `inRange` is 0. Otherwise `inRange` is 1.
- R7: With transposition, `stride` is 1 shifted left by (13 plus the X drop). Without it, `stride` is 1 shifted left by (14 plus the Y drop).
- R8: A request with `reqValid` high at a rising edge shows its results, with `rspValid` high, right after that edge. `rspValid` is low after any edge at which `reqValid` was low.
- R9: While `reqValid` is low, `addr`, `inRange` and `stride` keep the values of the last accepted request.
- R10: While `rstN` is low, `rspValid`, `addr`, `inRange` and `stride` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe; inputs are taken at the rising edge |
| fmt | input | 2 | Pixel format code |
| orient | input | 3 | View code: bit 0 inverts X, bit 1 inverts Y, bit 2 transposes |
| xIn | input | 16 | Pixel X coordinate |
| yIn | input | 16 | Pixel Y coordinate |
| rspValid | output | 1 | Result strobe |
| addr | output | 32 | Generated view address, 0 when out of range |
| inRange | output | 1 | Coordinate lay within the container |
| stride | output | 32 | Line stride for the chosen format and view |

## Verification
The assertions run on every cycle and cover these properties:
- the response strobe tracks the request one cycle later;
- results stay frozen between requests;
- an out-of-range result carries a zero address;
- the stride always has exactly one bit set;
- a valid address carries the view and format codes of the request that produced it;
- page-mode addresses have an empty low part.

The field arithmetic can only be shown by the bench's scenarios, which compare against an independent model across every format and view code. That arithmetic covers the mask width per format, mirroring by XOR, transposition order and the drop shift. The bench scenarios also probe the mask edges, where the last legal coordinate and the first illegal one meet.

// File: rtl/tva_pkg.sv
package tva_pkg;

  typedef enum logic [1:0] {
    FMT_TILE8  = 2'd0,
    FMT_TILE16 = 2'd1,
    FMT_TILE32 = 2'd2,
    FMT_PAGE   = 2'd3
  } pixFmt_t;

  // Strobes from the control side to the datapath
  typedef struct packed {
    logic capture;
  } tvaStrobe_t;

  // Number of coordinate bits dropped per axis
  typedef struct packed {
    logic [5:0] xDrop;
    logic [5:0] yDrop;
  } fmtGeom_t;

  function automatic fmtGeom_t geomOf(input logic [1:0] fmtCode,
                                      input logic [5:0] wBits,
                                      input logic [5:0] hBits);
    fmtGeom_t g;
    unique case (pixFmt_t'(fmtCode))
      FMT_TILE8:  begin g.xDrop = 6'd0;  g.yDrop = 6'd0;  end
      FMT_TILE16: begin g.xDrop = 6'd0;  g.yDrop = 6'd1;  end
      FMT_TILE32: begin g.xDrop = 6'd1;  g.yDrop = 6'd1;  end
      default:    begin g.xDrop = wBits; g.yDrop = hBits; end
    endcase
    return g;
  endfunction

endpackage

// File: rtl/tva_ctrl.sv
module tva_ctrl #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output tva_pkg::tvaStrobe_t strobe,
  output logic                rspValid
);

  assign strobe.capture = reqValid;

  generate
    if (REG_OUT) begin : g_reg
      logic rspQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) rspQ <= 1'b0;
        else       rspQ <= reqValid;
      end
      assign rspValid = rspQ;
    end else begin : g_comb
      assign rspValid = reqValid;
    end
  endgenerate

endmodule

// File: rtl/tva_datapath.sv
module tva_datapath #(
  parameter int WIDTH_BITS  = 14,
  parameter int HEIGHT_BITS = 13,
  parameter int COORD_W     = 16,
  parameter bit REG_OUT     = 1'b1,
  parameter int ADDR_W      = WIDTH_BITS + HEIGHT_BITS + 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  tva_pkg::tvaStrobe_t strobe,
  input  logic [1:0]          fmt,
  input  logic [2:0]          orient,
  input  logic [COORD_W-1:0]  xIn,
  input  logic [COORD_W-1:0]  yIn,
  output logic [ADDR_W-1:0]   addr,
  output logic                inRange,
  output logic [ADDR_W-1:0]   stride
);
  import tva_pkg::*;

  localparam int FMT_LSB = WIDTH_BITS + HEIGHT_BITS;
  localparam logic [5:0] W6 = 6'(WIDTH_BITS);
  localparam logic [5:0] H6 = 6'(HEIGHT_BITS);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  fmtGeom_t          geom;
  logic [5:0]        xBits, yBits, dropSum;
  logic [ADDR_W-1:0] xMask, yMask, xExt, yExt, xEff, yEff;
  logic [ADDR_W-1:0] offs, placed, tagBits;
  logic              rangeOk;
  logic [ADDR_W-1:0] addrC, strideC;

  always_comb begin
    geom    = geomOf(fmt, W6, H6);
    xBits   = W6 - geom.xDrop;
    yBits   = H6 - geom.yDrop;
    dropSum = geom.xDrop + geom.yDrop;
    xMask   = (ONE << xBits) - ONE;
    yMask   = (ONE << yBits) - ONE;
    xExt    = ADDR_W'(xIn);
    yExt    = ADDR_W'(yIn);
    rangeOk = (xExt <= xMask) && (yExt <= yMask);
    xEff    = orient[0] ? (xExt ^ xMask) : xExt;
    yEff    = orient[1] ? (yExt ^ yMask) : yExt;
    offs    = orient[2] ? ((xEff << yBits) + yEff) : ((yEff << xBits) + xEff);
    placed  = offs << dropSum;
    tagBits = ADDR_W'({orient, fmt}) << FMT_LSB;
    addrC   = rangeOk ? (tagBits | placed) : '0;
    strideC = orient[2] ? (ONE << (H6 + geom.xDrop)) : (ONE << (W6 + geom.yDrop));
  end

  generate
    if (REG_OUT) begin : g_reg
      logic [ADDR_W-1:0] addrQ, strideQ;
      logic              rangeQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          addrQ   <= '0;
          strideQ <= '0;
          rangeQ  <= 1'b0;
        end else if (strobe.capture) begin
          addrQ   <= addrC;
          strideQ <= strideC;
          rangeQ  <= rangeOk;
        end
      end
      assign addr    = addrQ;
      assign stride  = strideQ;
      assign inRange = rangeQ;
    end else begin : g_comb
      assign addr    = addrC;
      assign stride  = strideC;
      assign inRange = rangeOk;
    end
  endgenerate

endmodule

// File: rtl/tiled_view_addr.sv
module tiled_view_addr #(
  parameter int WIDTH_BITS  = 14,
  parameter int HEIGHT_BITS = 13,
  parameter int COORD_W     = 16,
  parameter bit REG_OUT     = 1'b1,
  localparam int ADDR_W     = WIDTH_BITS + HEIGHT_BITS + 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [1:0]         fmt,
  input  logic [2:0]         orient,
  input  logic [COORD_W-1:0] xIn,
  input  logic [COORD_W-1:0] yIn,
  output logic               rspValid,
  output logic [ADDR_W-1:0]  addr,
  output logic               inRange,
  output logic [ADDR_W-1:0]  stride
);

  tva_pkg::tvaStrobe_t strobe;

  tva_ctrl #(.REG_OUT(REG_OUT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .strobe   (strobe),
    .rspValid (rspValid)
  );

  tva_datapath #(
    .WIDTH_BITS  (WIDTH_BITS),
    .HEIGHT_BITS (HEIGHT_BITS),
    .COORD_W     (COORD_W),
    .REG_OUT     (REG_OUT),
    .ADDR_W      (ADDR_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .fmt     (fmt),
    .orient  (orient),
    .xIn     (xIn),
    .yIn     (yIn),
    .addr    (addr),
    .inRange (inRange),
    .stride  (stride)
  );

endmodule

// File: rtl/tiled_view_addr_chk.sv
module tiled_view_addr_chk #(
  parameter int WIDTH_BITS  = 14,
  parameter int HEIGHT_BITS = 13,
  parameter int COORD_W     = 16,
  parameter bit REG_OUT     = 1'b1,
  parameter int ADDR_W      = WIDTH_BITS + HEIGHT_BITS + 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic [1:0]         fmt,
  input logic [2:0]         orient,
  input logic [COORD_W-1:0] xIn,
  input logic [COORD_W-1:0] yIn,
  input logic               rspValid,
  input logic [ADDR_W-1:0]  addr,
  input logic               inRange,
  input logic [ADDR_W-1:0]  stride
);
  localparam int FMT_LSB  = WIDTH_BITS + HEIGHT_BITS;
  localparam int VIEW_LSB = FMT_LSB + 2;

  // R6: an out-of-range result never carries an address
  a_r6_zero_when_outside: assert property (@(posedge clk) disable iff (!rstN)
    !inRange |-> addr == '0);

  // R7: the stride is a single power of two for every response
  a_r7_stride_onehot: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $countones(stride) == 1);

  // R3: page mode leaves the low part of a valid address empty
  a_r3_page_low_empty: assert property (@(posedge clk) disable iff (!rstN)
    (inRange && addr[FMT_LSB +: 2] == 2'd3) |-> addr[FMT_LSB-1:0] == '0);

  generate
    if (REG_OUT) begin : g_reg
      // R8: the response strobe follows the request by one edge
      a_r8_rsp_follows_req: assert property (@(posedge clk) disable iff (!rstN)
        reqValid |=> rspValid);
      a_r8_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rstN)
        !reqValid |=> !rspValid);
      // R9: results are frozen while no request is presented
      a_r9_hold_addr: assert property (@(posedge clk) disable iff (!rstN)
        !reqValid |=> ($stable(addr) && $stable(stride) && $stable(inRange)));
      // R2: a valid result carries the view code of its request
      a_r2_view_tag: assert property (@(posedge clk) disable iff (!rstN)
        reqValid |=> (!inRange || addr[VIEW_LSB +: 3] == $past(orient)));
      // R1: a valid result carries the format code of its request
      a_r1_fmt_tag: assert property (@(posedge clk) disable iff (!rstN)
        reqValid |=> (!inRange || addr[FMT_LSB +: 2] == $past(fmt)));
    end else begin : g_comb
      a_r8_rsp_same_cycle: assert property (@(posedge clk) disable iff (!rstN)
        rspValid == reqValid);
      a_r2_view_tag: assert property (@(posedge clk) disable iff (!rstN)
        (reqValid && inRange) |-> addr[VIEW_LSB +: 3] == orient);
      a_r1_fmt_tag: assert property (@(posedge clk) disable iff (!rstN)
        (reqValid && inRange) |-> addr[FMT_LSB +: 2] == fmt);
    end
  endgenerate

endmodule

bind tiled_view_addr tiled_view_addr_chk #(
  .WIDTH_BITS  (WIDTH_BITS),
  .HEIGHT_BITS (HEIGHT_BITS),
  .COORD_W     (COORD_W),
  .REG_OUT     (REG_OUT),
  .ADDR_W      (ADDR_W)
) u_chk (.*);

// File: tb/tiled_view_addr_bench.sv
`timescale 1ns/1ps
module tiled_view_addr_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  fmt = '0;
  logic [2:0]  orient = '0;
  logic [15:0] xIn = '0;
  logic [15:0] yIn = '0;
  logic        rspValid;
  logic [31:0] addr;
  logic        inRange;
  logic [31:0] stride;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  tiled_view_addr u_tiled_view_addr (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .fmt(fmt), .orient(orient),
    .xIn(xIn), .yIn(yIn), .rspValid(rspValid), .addr(addr),
    .inRange(inRange), .stride(stride)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Independent model built from the requirement text
  function automatic void model(input int f, input int o, input int x, input int y,
                                output logic [31:0] eAddr, output logic eIn,
                                output logic [31:0] eStride);
    int xd, yd, xb, yb;
    longint xm, ym, xv, yv, off;
    case (f)
      0: begin xd = 0;  yd = 0;  end
      1: begin xd = 0;  yd = 1;  end
      2: begin xd = 1;  yd = 1;  end
      default: begin xd = 14; yd = 13; end
    endcase
    xb = 14 - xd;  yb = 13 - yd;
    xm = (longint'(1) << xb) - 1;
    ym = (longint'(1) << yb) - 1;
    eStride = (o & 4) != 0 ? 32'(longint'(1) << (13 + xd)) : 32'(longint'(1) << (14 + yd));
    if (x > xm || y > ym) begin
      eAddr = 32'h0;
      eIn = 1'b0;
    end else begin
      xv = ((o & 1) != 0) ? (x ^ xm) : x;
      yv = ((o & 2) != 0) ? (y ^ ym) : y;
      off = ((o & 4) != 0) ? (xv * (longint'(1) << yb) + yv) : (yv * (longint'(1) << xb) + xv);
      off = off * (longint'(1) << (xd + yd));
      eAddr = 32'(longint'(o) * (longint'(1) << 29) + longint'(f) * (longint'(1) << 27) + off);
      eIn = 1'b1;
    end
  endfunction

  // Present one request at a falling edge; results are sampled one cycle later
  task automatic issue(input int f, input int o, input int x, input int y);
    @(negedge clk);
    fmt = 2'(f); orient = 3'(o); xIn = 16'(x); yIn = 16'(y); reqValid = 1'b1;
    @(negedge clk);
  endtask

  task automatic checkOne(input string req, input int f, input int o, input int x, input int y);
    logic [31:0] eA, eS;
    logic eI;
    issue(f, o, x, y);
    model(f, o, x, y, eA, eI, eS);
    check({req, " addr"}, addr, eA);
    check({req, " inRange"}, 32'(inRange), 32'(eI));
    check({req, " stride"}, stride, eS);
    check("R8 rspValid", 32'(rspValid), 32'd1);
  endtask

  task automatic testReset();
    check("R10 reset rspValid", 32'(rspValid), 32'd0);
    check("R10 reset addr", addr, 32'd0);
    check("R10 reset inRange", 32'(inRange), 32'd0);
    check("R10 reset stride", stride, 32'd0);
  endtask

  task automatic testKnown();
    issue(0, 0, 5, 3);
    check("R5 plain 8-bit offset", addr, 32'h0000_C005);
    check("R7 plain 8-bit stride", stride, 32'h0000_4000);
    issue(2, 6, 2, 1);
    check("R4 R5 transposed 32-bit addr", addr, 32'hD000_BFF8);
    check("R7 transposed 32-bit stride", stride, 32'h0000_4000);
    issue(3, 5, 0, 0);
    check("R1 R2 page tag", addr, 32'hB800_0000);
  endtask

  task automatic testSweep();
    for (int f = 0; f < 4; f++) begin
      for (int o = 0; o < 8; o++) begin
        checkOne("R1 R2 R3 R4 R5 origin", f, o, 0, 0);
        checkOne("R3 R4 R5 small", f, o, 3, 2);
        checkOne("R3 R4 R5 mixed", f, o, 1234, 567);
        checkOne("R3 R6 edge", f, o, (1 << (14 - (f == 2 ? 1 : 0))) - 1,
                 (1 << (13 - (f == 0 ? 0 : 1))) - 1);
      end
    end
  endtask

  task automatic testRange();
    checkOne("R6 8-bit x over", 0, 0, 16384, 0);
    checkOne("R6 8-bit y over", 0, 3, 0, 8192);
    checkOne("R6 16-bit y edge", 1, 0, 0, 4095);
    checkOne("R6 16-bit y over", 1, 0, 0, 4096);
    checkOne("R6 32-bit x over", 2, 7, 8192, 0);
    checkOne("R6 page x over", 3, 0, 1, 0);
    check("R6 page x over flag", 32'(inRange), 32'd0);
    checkOne("R6 page y over", 3, 4, 0, 1);
  endtask

  task automatic testHold();
    logic [31:0] keepA, keepS;
    issue(1, 2, 77, 88);
    keepA = addr; keepS = stride;
    @(negedge clk);
    reqValid = 1'b0; fmt = 2'd0; orient = 3'd7; xIn = 16'd5; yIn = 16'd9;
    @(negedge clk);
    check("R8 rspValid low without request", 32'(rspValid), 32'd0);
    @(negedge clk);
    check("R9 addr held", addr, keepA);
    check("R9 stride held", stride, keepS);
    check("R9 inRange held", 32'(inRange), 32'd1);
    // Latency: a new request is not visible before its edge
    fmt = 2'd0; orient = 3'd0; xIn = 16'd1; yIn = 16'd0; reqValid = 1'b1;
    #1;
    check("R8 no early result", addr, keepA);
    @(negedge clk);
    check("R8 result after one edge", addr, 32'h0000_0001);
    reqValid = 1'b0;
  endtask

  initial begin
    #3;
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testKnown();
    testSweep();
    testRange();
    testHold();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule